// File: doc/BRIEF.md
# Stuck Bus Guard

This block watches the card-side clock and data lines of a two-wire bus buffer (I2C/SMBus) and finds a bus that is hung low. It counts clock-enable ticks while either line reads low. When that count reaches the timeout, it sets a fault flag. A low level on either line at any point keeps the count running, and a cycle in which both lines read high sets it back to zero. The fault output is active low, in open-drain style.

The automatic-disconnect pin chooses what happens next. If it is high when the timeout expires, the block asks the buffer to break the link between the card side and the backplane side. It then drives a bounded burst of clock pulses on the card-side SCL and follows it with a stop condition. The link is restored once both card-side lines read high. If the pin is low, the block raises the fault flag only. The link stays up and nothing is driven.

The pin is sampled only when a recovery would start. Changing it during a burst has no effect on that burst. All inputs are expected to be already synchronised to `clk`. The drive outputs are open-drain enables: a 1 pulls the line low and a 0 releases it. All pins are plain level signals and no data stream crosses the block.

Top module: `stuck_bus_guard`

## Requirements
- R1: After reset, fault_n is 1 and disconnect, scl_drive_low and sda_drive_low are 0.
- R2: Ticks are counted only in cycles with tick high. fault_n goes low on the clock edge after the TIMEOUT_TICKS-th consecutive tick in which scl_in or sda_in reads low. With no ticks, a low line never raises the fault.
- R3: A cycle in which both lines read high restarts the count from zero, so two low spans that are each shorter than the timeout never raise the fault.
- R4: With auto_disc_en high, disconnect rises on the same edge as the fault. It stays high through the recovery and while any line is still low after the stop condition. It falls on the edge after both lines read high.
- R5: In each recovery clock pulse, scl_drive_low is 1 for HALF_TICKS ticks and then 0 for HALF_TICKS ticks. No more than MAX_PULSES pulses are produced in one recovery.
- R6: If sda_in reads high at the end of a pulse's high phase, no further pulse follows and the stop condition begins.
- R7: The stop condition has three steps of HALF_TICKS ticks each, in this order: both lines driven low (snapshot {disconnect,scl_drive_low,sda_drive_low} = 111), then SCL released with SDA still low (101), then both released (100).
- R8: With auto_disc_en low, a timeout only drives fault_n low. disconnect, scl_drive_low and sda_drive_low stay 0.
- R9: fault_n returns to 1 on the edge after a cycle in which both lines read high.
- R10: scl_drive_low or sda_drive_low is 1 only while disconnect is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Clock enable that times both the timeout and the recovery clock |
| scl_in | input | 1 | Sampled card-side SCL level |
| sda_in | input | 1 | Sampled card-side SDA level |
| auto_disc_en | input | 1 | 1 = disconnect and recover on timeout; 0 = flag only |
| fault_n | output | 1 | Stuck-bus fault, active low |
| disconnect | output | 1 | Request to break the card-to-backplane link |
| scl_drive_low | output | 1 | 1 pulls card-side SCL low |
| sda_drive_low | output | 1 | 1 pulls card-side SDA low |

## Verification
Two situations are hard to reach from the ports. The first is a device that lets go of SDA partway through the pulse burst. The second is a device that never lets go, which forces the full burst and then the hold-disconnected state. The bench models the wired-AND bus around the block. An external holder pulls SDA low and counts the block's own SCL pulls, then releases SDA after a chosen pulse, so the early-stop path is reached on a known pulse. When the holder never releases, the block runs all pulses, the stop condition and the hold state. A scoreboard compares every change of the four outputs with the sequence the requirements predict. The tick is toggled on alternate cycles so that the phase lengths are checked in clock cycles.

// File: rtl/sbg_pkg.sv
package sbg_pkg;

  typedef enum logic [2:0] {
    SEQ_IDLE     = 3'd0,
    SEQ_CLK_LO   = 3'd1,
    SEQ_CLK_HI   = 3'd2,
    SEQ_STOP_LO  = 3'd3,
    SEQ_STOP_SCL = 3'd4,
    SEQ_STOP_REL = 3'd5,
    SEQ_HOLD     = 3'd6
  } seq_state_e;

endpackage

// File: rtl/sbg_stuck_timer.sv
module sbg_stuck_timer #(
  parameter int TIMEOUT_TICKS = 30000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic scl_i,
  input  logic sda_i,
  output logic stuck_o,
  output logic lines_high_o
);

  localparam int CNT_W = $clog2(TIMEOUT_TICKS + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(TIMEOUT_TICKS);

  logic [CNT_W-1:0] cnt_q;

  assign lines_high_o = scl_i & sda_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (lines_high_o) begin
      cnt_q <= '0;
    end else if (tick && (cnt_q != CNT_MAX)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign stuck_o = (cnt_q == CNT_MAX);

  // R3: a both-high cycle leaves no stuck indication on the next cycle
  assert_timer_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
    lines_high_o |=> !stuck_o);

endmodule

// File: rtl/sbg_fault_flag.sv
module sbg_fault_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic stuck_i,
  input  logic lines_high_i,
  output logic fault_o
);

  logic fault_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_q <= 1'b0;
    end else if (lines_high_i) begin
      fault_q <= 1'b0;
    end else if (stuck_i) begin
      fault_q <= 1'b1;
    end
  end

  assign fault_o = fault_q;

  assert_fault_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (stuck_i && !lines_high_i) |=> fault_q);

  assert_fault_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    lines_high_i |=> !fault_q);

endmodule

// File: rtl/sbg_recovery_seq.sv
module sbg_recovery_seq
  import sbg_pkg::*;
#(
  parameter int HALF_TICKS = 5,
  parameter int MAX_PULSES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic start_i,
  input  logic sda_i,
  input  logic lines_high_i,
  output logic busy_o,
  output logic scl_low_o,
  output logic sda_low_o
);

  localparam int PH_W = (HALF_TICKS > 1) ? $clog2(HALF_TICKS) : 1;
  localparam int PC_W = $clog2(MAX_PULSES + 1);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(HALF_TICKS - 1);
  localparam logic [PC_W-1:0] PC_MAX  = PC_W'(MAX_PULSES);

  seq_state_e       state_q, state_d;
  logic [PH_W-1:0]  ph_q;
  logic [PC_W-1:0]  pcnt_q, pcnt_d;
  logic             adv;

  assign adv = tick && (ph_q == PH_LAST);

  always_comb begin
    state_d = state_q;
    pcnt_d  = pcnt_q;
    unique case (state_q)
      SEQ_IDLE: begin
        if (start_i) begin
          state_d = SEQ_CLK_LO;
          pcnt_d  = '0;
        end
      end
      SEQ_CLK_LO: begin
        if (adv) state_d = SEQ_CLK_HI;
      end
      SEQ_CLK_HI: begin
        if (adv) begin
          pcnt_d = pcnt_q + 1'b1;
          if (sda_i || (pcnt_d == PC_MAX)) state_d = SEQ_STOP_LO;
          else                             state_d = SEQ_CLK_LO;
        end
      end
      SEQ_STOP_LO: begin
        if (adv) state_d = SEQ_STOP_SCL;
      end
      SEQ_STOP_SCL: begin
        if (adv) state_d = SEQ_STOP_REL;
      end
      SEQ_STOP_REL: begin
        if (adv) state_d = lines_high_i ? SEQ_IDLE : SEQ_HOLD;
      end
      SEQ_HOLD: begin
        if (lines_high_i) state_d = SEQ_IDLE;
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      ph_q    <= '0;
      pcnt_q  <= '0;
    end else begin
      state_q <= state_d;
      pcnt_q  <= pcnt_d;
      if (state_d != state_q)                              ph_q <= '0;
      else if (tick && state_q != SEQ_IDLE && state_q != SEQ_HOLD) ph_q <= ph_q + 1'b1;
    end
  end

  assign busy_o    = (state_q != SEQ_IDLE);
  assign scl_low_o = (state_q == SEQ_CLK_LO) || (state_q == SEQ_STOP_LO);
  assign sda_low_o = (state_q == SEQ_STOP_LO) || (state_q == SEQ_STOP_SCL);

  // R5: a new low phase never begins once the pulse budget is spent
  assert_pulse_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SEQ_CLK_LO) |-> (pcnt_q < PC_MAX));

  // R6: released SDA at the end of a high phase ends the burst
  assert_early_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SEQ_CLK_HI && adv && sda_i) |=> (state_q == SEQ_STOP_LO));

  // R7: SCL is released during the stop only right after both lines were held low
  assert_stop_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SEQ_STOP_SCL) |-> ($past(state_q) == SEQ_STOP_SCL || $past(state_q) == SEQ_STOP_LO));

endmodule

// File: rtl/stuck_bus_guard.sv
module stuck_bus_guard #(
  parameter int TIMEOUT_TICKS = 30000,
  parameter int HALF_TICKS    = 5,
  parameter int MAX_PULSES    = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic scl_in,
  input  logic sda_in,
  input  logic auto_disc_en,
  output logic fault_n,
  output logic disconnect,
  output logic scl_drive_low,
  output logic sda_drive_low
);

  logic stuck;
  logic lines_high;
  logic fault;
  logic busy;
  logic start;

  sbg_stuck_timer #(.TIMEOUT_TICKS(TIMEOUT_TICKS)) u_timer (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick         (tick),
    .scl_i        (scl_in),
    .sda_i        (sda_in),
    .stuck_o      (stuck),
    .lines_high_o (lines_high)
  );

  sbg_fault_flag u_flag (
    .clk          (clk),
    .rst_n        (rst_n),
    .stuck_i      (stuck),
    .lines_high_i (lines_high),
    .fault_o      (fault)
  );

  assign start = stuck && !lines_high && auto_disc_en && !busy;

  sbg_recovery_seq #(.HALF_TICKS(HALF_TICKS), .MAX_PULSES(MAX_PULSES)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick         (tick),
    .start_i      (start),
    .sda_i        (sda_in),
    .lines_high_i (lines_high),
    .busy_o       (busy),
    .scl_low_o    (scl_drive_low),
    .sda_low_o    (sda_drive_low)
  );

  assign fault_n    = ~fault;
  assign disconnect = busy;

  assert_drive_needs_break_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_drive_low || sda_drive_low) |-> disconnect);

  assert_flag_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!disconnect && !auto_disc_en) |=> !disconnect);

  assert_break_with_fault_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(disconnect) |-> !fault_n);

endmodule

// File: tb/stuck_bus_guard_bench.sv
`timescale 1ns/1ps
module stuck_bus_guard_bench;

  localparam real PERIOD = 5.0;
  localparam int  TMO    = 20;
  localparam int  HALF   = 3;
  localparam int  MAXP   = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_alt = 1'b0;
  logic tick_const = 1'b1;
  logic tick_ph = 1'b0;
  logic tick;
  logic ext_scl_low = 1'b0;
  logic ext_sda_low = 1'b0;
  logic auto_disc_en = 1'b0;
  logic scl_line, sda_line;
  logic fault_n, disconnect, scl_drive_low, sda_drive_low;

  int checks = 0;
  int errors = 0;
  logic [3:0] exp_q[$];
  string      req_q[$];
  logic [3:0] last_snap = 4'b0001;
  logic       mon_on = 1'b0;

  always #(PERIOD/2) clk = ~clk;
  always @(negedge clk) tick_ph <= ~tick_ph;
  assign tick = tick_alt ? tick_ph : tick_const;

  assign scl_line = !(scl_drive_low || ext_scl_low);
  assign sda_line = !(sda_drive_low || ext_sda_low);

  stuck_bus_guard #(.TIMEOUT_TICKS(TMO), .HALF_TICKS(HALF), .MAX_PULSES(MAXP)) u_stuck_bus_guard (
    .clk           (clk),
    .rst_n         (rst_n),
    .tick          (tick),
    .scl_in        (scl_line),
    .sda_in        (sda_line),
    .auto_disc_en  (auto_disc_en),
    .fault_n       (fault_n),
    .disconnect    (disconnect),
    .scl_drive_low (scl_drive_low),
    .sda_drive_low (sda_drive_low)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic push_exp(input logic [3:0] v, input string req);
    exp_q.push_back(v);
    req_q.push_back(req);
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // monitor: snapshot {disconnect, scl_drive_low, sda_drive_low, fault_n}
  always @(negedge clk) begin
    logic [3:0] cur;
    cur = {disconnect, scl_drive_low, sda_drive_low, fault_n};
    if (mon_on && cur !== last_snap) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R10 unexpected output change actual %b expected none", cur);
      end else begin
        logic [3:0] e;
        string r;
        e = exp_q.pop_front();
        r = req_q.pop_front();
        if (cur !== e) begin
          errors++;
          $display("FAIL %s output sequence actual %b expected %b", r, cur, e);
        end
      end
      last_snap = cur;
    end
  end

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog run did not complete actual 1 expected 0");
    finish_run();
  end

  initial begin
    int n;
    int bad;
    realtime t0, t1;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check({disconnect, scl_drive_low, sda_drive_low, fault_n} == 4'b0001, "R1",
          "reset outputs", {disconnect, scl_drive_low, sda_drive_low, fault_n}, 1);
    mon_on = 1'b1;

    // R3: two short low spans separated by a both-high cycle
    bad = 0;
    ext_sda_low = 1'b1;
    repeat (15) begin @(negedge clk); if (!fault_n) bad++; end
    ext_sda_low = 1'b0;
    @(negedge clk);
    ext_sda_low = 1'b1;
    repeat (15) begin @(negedge clk); if (!fault_n) bad++; end
    ext_sda_low = 1'b0;
    repeat (3) @(negedge clk);
    check(bad == 0, "R3", "fault during short lows", bad, 0);

    // R2: no ticks means no count
    tick_const = 1'b0;
    ext_scl_low = 1'b1;
    repeat (60) @(negedge clk);
    check(fault_n == 1'b1, "R2", "fault without ticks", fault_n, 1);
    ext_scl_low = 1'b0;
    @(negedge clk);
    tick_const = 1'b1;

    // R8 / R2 / R9: flag-only mode, exact timeout
    auto_disc_en = 1'b0;
    push_exp(4'b0000, "R8");
    push_exp(4'b0001, "R9");
    ext_scl_low = 1'b1;
    n = 0;
    do begin @(negedge clk); n++; end while (fault_n && n < 200);
    check(n == TMO + 1, "R2", "cycles to fault", n, TMO + 1);
    bad = 0;
    repeat (40) begin
      @(negedge clk);
      if (disconnect || scl_drive_low || sda_drive_low) bad++;
    end
    check(bad == 0, "R8", "drive in flag-only mode", bad, 0);
    ext_scl_low = 1'b0;
    drain();

    // R6 / R7 / R4 / R9: SDA let go after the third pulse
    auto_disc_en = 1'b1;
    tick_alt = 1'b1;
    push_exp(4'b1100, "R4");
    push_exp(4'b1000, "R5"); push_exp(4'b1100, "R5");
    push_exp(4'b1000, "R5"); push_exp(4'b1100, "R5");
    push_exp(4'b1000, "R5");
    push_exp(4'b1001, "R9");
    push_exp(4'b1111, "R6");
    push_exp(4'b1011, "R7");
    push_exp(4'b1001, "R7");
    push_exp(4'b0001, "R4");
    ext_sda_low = 1'b1;
    repeat (3) @(posedge scl_drive_low);
    @(negedge clk);
    ext_sda_low = 1'b0;
    drain();
    check(disconnect == 1'b0, "R4", "link restored", disconnect, 0);

    // R5 / R7 / R4: SDA never let go
    push_exp(4'b1100, "R4");
    for (int i = 0; i < MAXP - 1; i++) begin
      push_exp(4'b1000, "R5");
      push_exp(4'b1100, "R5");
    end
    push_exp(4'b1000, "R5");
    push_exp(4'b1110, "R7");
    push_exp(4'b1010, "R7");
    push_exp(4'b1000, "R7");
    ext_sda_low = 1'b1;
    @(negedge scl_drive_low);
    t0 = $realtime;
    @(posedge scl_drive_low);
    t1 = $realtime;
    check((t1 - t0) == 2.0 * HALF * PERIOD, "R5", "high phase ns",
          int'(t1 - t0), int'(2.0 * HALF * PERIOD));
    drain();
    repeat (20) @(negedge clk);
    check(disconnect == 1'b1 && fault_n == 1'b0 && !scl_drive_low, "R4",
          "held disconnected with no pulses", {disconnect, fault_n, scl_drive_low}, 3'b100);
    push_exp(4'b0001, "R4");
    ext_sda_low = 1'b0;
    drain();
    check(exp_q.size() == 0, "R9", "pending items", exp_q.size(), 0);

    finish_run();
  end

endmodule